// File: doc/BRIEF.md
# ATAPI Packet Command PIO Data Engine

The block sits on the device side of an ATA task-file interface and carries out one PACKET command at a time in programmed I/O mode. The host first sets a byte-count limit in two 8-bit limit registers, then writes the packet command code. The device shows busy for one cycle. It then opens a first DRQ window in which the host writes a 12-byte command packet as six 16-bit words through the data register.

For a READ(10) packet the engine computes the transfer length from the block count, with 2048-byte logical blocks. It returns the data through the data register in bursts that never exceed the even-rounded limit. Each burst is announced by an interrupt and is read inside its own DRQ window. A final interrupt and a clean ready status close the command. A read of the status register acknowledges any pending interrupt.

The sector data comes from a small internal store of STORE_BLOCKS blocks. A byte-wide fill port loads the store. Logical block addresses are mapped onto the store modulo its block count.

Top module: `pkt_pio_engine`

## Requirements
- R1: After reset the status byte reads 0x40 and intrq is low. The status bit positions are: BSY bit 7, DRDY bit 6, DF bit 5, DRQ bit 3, ERR bit 0; DRDY is always set and DF is always clear. The register addresses are: data 0, limit low 4, limit high 5, status on read and command on write 7.
- R2: Writing command 0xA0 while idle, with a limit of 2 or more, gives status 0xC0 (busy) for exactly one cycle. The status then becomes 0x48 with intrq low while the packet is awaited.
- R3: The packet is six data-register writes. Packet byte 2k is the low half of word k and byte 2k+1 is the high half. Byte 0 is the opcode; 0x28 means READ(10). Bytes 2..5 hold the LBA with the most significant byte first, and bytes 7..8 hold the block count with the most significant byte first.
- R4: The limit is rounded down to even. Each burst carries min(limit, remaining) bytes, where the transfer totals count × 2048 bytes.
- R5: Before each burst intrq rises, and the status then reads 0x48. Once the last word of a burst that is not the final one has been read, the status reads 0xC0 until the next burst opens.
- R6: Each data word is {byte 2i+1, byte 2i} of the transfer, in ascending order. Transfer block k is taken from store block (LBA + k) mod STORE_BLOCKS. In the store, byte address = block × 2048 + offset.
- R7: After the last word of the last burst, intrq is raised in the next cycle and the status reads 0x40.
- R8: A read of the status register clears a pending intrq.
- R9: If the packet command is issued with the limit rounded down to zero, the command is aborted. No packet phase follows: the status reads 0x41 and intrq is raised.
- R10: If the opcode is anything other than 0x28, the status reads 0x41 and intrq is raised right after the sixth packet word. The next accepted command clears ERR.
- R11: A READ(10) with a block count of zero completes right after the sixth packet word, with status 0x40 and intrq raised.
- R12: Command codes other than 0xA0 are ignored, and so are command or limit writes made while a command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Task-file register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational from reg_addr) |
| intrq | output | 1 | Interrupt request to the host |
| fill_we | input | 1 | Sector store byte write enable |
| fill_addr | input | log2(STORE_BLOCKS×2048) | Sector store byte address |
| fill_byte | input | 8 | Sector store byte data |

## Verification
The assertions assume a host that never raises reg_rd and reg_wr in the same cycle. They also assume the host reads the data register only while DRQ is shown and leaves the fill port quiet once commands start. The bench drives one strobe per task call, with an idle cycle between accesses. It loads the store completely before the first command and reads data words only inside the burst windows it has been told to expect. Burst lengths are confirmed by the status seen right after the last expected word of each burst.

// File: rtl/pkt_pio_pkg.sv
package pkt_pio_pkg;
   localparam int STB_BSY  = 7;
   localparam int STB_DRDY = 6;
   localparam int STB_DF   = 5;
   localparam int STB_DRQ  = 3;
   localparam int STB_ERR  = 0;

   localparam logic [2:0] RA_DATA   = 3'd0;
   localparam logic [2:0] RA_LIM_LO = 3'd4;
   localparam logic [2:0] RA_LIM_HI = 3'd5;
   localparam logic [2:0] RA_STCMD  = 3'd7;

   localparam logic [7:0] CODE_PACKET = 8'hA0;
   localparam logic [7:0] OPC_READ10  = 8'h28;

   typedef enum logic [2:0] {
      PH_IDLE, PH_CMDBSY, PH_PKT, PH_PREP, PH_DATA
   } phase_t;
endpackage

// File: rtl/pkt_intake.sv
module pkt_intake #(
   parameter int PKT_WORDS = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        wr_en,
   input  logic [15:0] wdata,
   output logic        done,
   output logic [7:0]  opcode,
   output logic [31:0] lba,
   output logic [15:0] nblocks
);
   localparam int CW = $clog2(PKT_WORDS);

   if (PKT_WORDS < 5) begin : g_bad_len
      $error("pkt_intake: packet must hold at least 5 words");
   end

   logic [CW-1:0] cnt;

   assign done = wr_en && (cnt == CW'(PKT_WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         opcode  <= '0;
         lba     <= '0;
         nblocks <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (wr_en) begin
         cnt <= done ? '0 : cnt + 1'b1;
         case (cnt)
            CW'(0): opcode <= wdata[7:0];
            CW'(1): begin
               lba[31:24] <= wdata[7:0];
               lba[23:16] <= wdata[15:8];
            end
            CW'(2): begin
               lba[15:8] <= wdata[7:0];
               lba[7:0]  <= wdata[15:8];
            end
            CW'(3): nblocks[15:8] <= wdata[15:8];
            CW'(4): nblocks[7:0]  <= wdata[7:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pkt_burst_sizer.sv
module pkt_burst_sizer #(
   parameter int CNT_W = 27,
   parameter int LIM_W = 16
) (
   input  logic [LIM_W-1:0] limit,
   input  logic [CNT_W-1:0] remaining,
   output logic [CNT_W-1:0] burst_bytes,
   output logic             limit_ok
);
   if (CNT_W <= LIM_W) begin : g_bad_w
      $error("pkt_burst_sizer: count must be wider than limit");
   end

   logic [LIM_W-1:0] lim_even;
   logic [CNT_W-1:0] lim_ext;

   always_comb begin
      lim_even    = limit & ~LIM_W'(1);
      lim_ext     = CNT_W'(lim_even);
      limit_ok    = (lim_even != '0);
      burst_bytes = (remaining < lim_ext) ? remaining : lim_ext;
   end
endmodule

// File: rtl/pkt_sector_store.sv
module pkt_sector_store #(
   parameter int DEPTH_WORDS = 2048
) (
   input  logic                         clk,
   input  logic                         fill_we,
   input  logic [$clog2(DEPTH_WORDS):0] fill_addr,
   input  logic [7:0]                   fill_byte,
   input  logic [$clog2(DEPTH_WORDS)-1:0] rd_addr,
   output logic [15:0]                  rd_word
);
   localparam int AW = $clog2(DEPTH_WORDS);

   if ((1 << AW) != DEPTH_WORDS) begin : g_bad_depth
      $error("pkt_sector_store: depth must be a power of two");
   end

   for (genvar lane = 0; lane < 2; lane++) begin : g_lane
      logic [7:0] bank [DEPTH_WORDS];
      always_ff @(posedge clk) begin
         if (fill_we && (fill_addr[0] == 1'(lane)))
            bank[fill_addr[AW:1]] <= fill_byte;
      end
      assign rd_word[lane*8 +: 8] = bank[rd_addr];
   end
endmodule

// File: rtl/pkt_pio_engine.sv
module pkt_pio_engine
   import pkt_pio_pkg::*;
#(
   parameter int BLOCK_BYTES  = 2048,
   parameter int STORE_BLOCKS = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  reg_addr,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        intrq,
   input  logic        fill_we,
   input  logic [$clog2(STORE_BLOCKS*BLOCK_BYTES)-1:0] fill_addr,
   input  logic [7:0]  fill_byte
);
   localparam int LIM_W  = 16;
   localparam int WPB    = BLOCK_BYTES / 2;
   localparam int WPB_W  = $clog2(WPB);
   localparam int SB_W   = $clog2(STORE_BLOCKS);
   localparam int DEPTH  = STORE_BLOCKS * WPB;
   localparam int BB_W   = $clog2(BLOCK_BYTES);
   localparam int CNT_W  = 16 + BB_W;

   if ((1 << BB_W) != BLOCK_BYTES || BLOCK_BYTES < 4) begin : g_bad_blk
      $error("pkt_pio_engine: block size must be a power of two of at least 4");
   end
   if ((1 << SB_W) != STORE_BLOCKS || STORE_BLOCKS < 2) begin : g_bad_store
      $error("pkt_pio_engine: store block count must be a power of two of at least 2");
   end

   phase_t           st;
   logic [LIM_W-1:0] lim_q;
   logic [CNT_W-1:0] remaining;
   logic [LIM_W-1:0] burst_left;
   logic [WPB_W-1:0] word_ptr;
   logic [31:0]      cur_lba;
   logic             intrq_q;
   logic             err_q;
   logic [7:0]       status_w;

   logic wr_cmd, wr_data, rd_data, rd_stat;
   assign wr_cmd  = reg_wr && (reg_addr == RA_STCMD);
   assign wr_data = reg_wr && (reg_addr == RA_DATA);
   assign rd_data = reg_rd && (reg_addr == RA_DATA);
   assign rd_stat = reg_rd && (reg_addr == RA_STCMD);

   logic        pkt_done;
   logic [7:0]  pkt_opcode;
   logic [31:0] pkt_lba;
   logic [15:0] pkt_nblocks;

   pkt_intake #(.PKT_WORDS(6)) i_intake (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (st == PH_IDLE),
      .wr_en   (wr_data && (st == PH_PKT)),
      .wdata   (reg_wdata),
      .done    (pkt_done),
      .opcode  (pkt_opcode),
      .lba     (pkt_lba),
      .nblocks (pkt_nblocks)
   );

   logic [CNT_W-1:0] burst_bytes;
   logic             limit_ok;

   pkt_burst_sizer #(.CNT_W(CNT_W), .LIM_W(LIM_W)) i_sizer (
      .limit       (lim_q),
      .remaining   (remaining),
      .burst_bytes (burst_bytes),
      .limit_ok    (limit_ok)
   );

   logic [15:0] store_word;

   pkt_sector_store #(.DEPTH_WORDS(DEPTH)) i_store (
      .clk       (clk),
      .fill_we   (fill_we),
      .fill_addr (fill_addr),
      .fill_byte (fill_byte),
      .rd_addr   ({cur_lba[SB_W-1:0], word_ptr}),
      .rd_word   (store_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= PH_IDLE;
         lim_q      <= '0;
         remaining  <= '0;
         burst_left <= '0;
         word_ptr   <= '0;
         cur_lba    <= '0;
         intrq_q    <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         if (rd_stat) intrq_q <= 1'b0;
         case (st)
            PH_IDLE: begin
               if (reg_wr && reg_addr == RA_LIM_LO) lim_q[7:0]  <= reg_wdata[7:0];
               if (reg_wr && reg_addr == RA_LIM_HI) lim_q[15:8] <= reg_wdata[7:0];
               if (wr_cmd && reg_wdata[7:0] == CODE_PACKET) begin
                  if (limit_ok) begin
                     err_q   <= 1'b0;
                     intrq_q <= 1'b0;
                     st      <= PH_CMDBSY;
                  end else begin
                     err_q   <= 1'b1;
                     intrq_q <= 1'b1;
                  end
               end
            end
            PH_CMDBSY: st <= PH_PKT;
            PH_PKT: begin
               if (pkt_done) begin
                  if (pkt_opcode != OPC_READ10) begin
                     err_q   <= 1'b1;
                     intrq_q <= 1'b1;
                     st      <= PH_IDLE;
                  end else if (pkt_nblocks == '0) begin
                     intrq_q <= 1'b1;
                     st      <= PH_IDLE;
                  end else begin
                     remaining <= {pkt_nblocks, {BB_W{1'b0}}};
                     cur_lba   <= pkt_lba;
                     word_ptr  <= '0;
                     st        <= PH_PREP;
                  end
               end
            end
            PH_PREP: begin
               burst_left <= burst_bytes[LIM_W:1];
               remaining  <= remaining - burst_bytes;
               intrq_q    <= 1'b1;
               st         <= PH_DATA;
            end
            PH_DATA: begin
               if (rd_data) begin
                  word_ptr   <= word_ptr + 1'b1;
                  if (&word_ptr) cur_lba <= cur_lba + 1;
                  burst_left <= burst_left - 1'b1;
                  if (burst_left == LIM_W'(1)) begin
                     if (remaining == '0) begin
                        intrq_q <= 1'b1;
                        st      <= PH_IDLE;
                     end else begin
                        st <= PH_PREP;
                     end
                  end
               end
            end
            default: st <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      status_w           = '0;
      status_w[STB_DRDY] = 1'b1;
      status_w[STB_BSY]  = (st == PH_CMDBSY) || (st == PH_PREP);
      status_w[STB_DRQ]  = (st == PH_PKT) || (st == PH_DATA);
      status_w[STB_ERR]  = err_q;
      status_w[STB_DF]   = 1'b0;
   end

   always_comb begin
      case (reg_addr)
         RA_DATA:   reg_rdata = (st == PH_DATA) ? store_word : 16'h0000;
         RA_LIM_LO: reg_rdata = {8'h00, lim_q[7:0]};
         RA_LIM_HI: reg_rdata = {8'h00, lim_q[15:8]};
         RA_STCMD:  reg_rdata = {8'h00, status_w};
         default:   reg_rdata = 16'h0000;
      endcase
   end

   assign intrq = intrq_q;
endmodule

// File: rtl/pkt_pio_checker.sv
module pkt_pio_checker
   import pkt_pio_pkg::*;
#(
   parameter int CNT_W = 27
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       reg_addr,
   input logic             reg_wr,
   input logic             reg_rd,
   input logic [7:0]       cmd_byte,
   input logic             intrq,
   input logic [7:0]       status,
   input phase_t           st,
   input logic [CNT_W-1:0] burst_bytes,
   input logic             limit_ok
);
   logic start_cmd;
   assign start_cmd = (st == PH_IDLE) && reg_wr && (reg_addr == RA_STCMD)
                      && (cmd_byte == CODE_PACKET);

   // R5: busy and data request never shown together
   p_no_bsy_drq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[STB_BSY] && status[STB_DRQ]));

   // R2: accepted command gives one busy cycle
   p_cmd_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_cmd && limit_ok) |=> (status == 8'hC0 && !intrq));

   // R2: busy is followed by the packet window
   p_busy_to_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_CMDBSY) |=> (status == 8'h48));

   // R9: zero limit aborts at once
   p_zero_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_cmd && !limit_ok) |=> (status == 8'h41 && intrq));

   // R8: status read acknowledges the interrupt
   p_stat_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !reg_wr && reg_addr == RA_STCMD &&
       (st == PH_DATA || st == PH_IDLE || st == PH_PKT)) |=> !intrq);

   // R4: every burst is non-empty and even
   p_burst_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_PREP) |-> (burst_bytes != '0 && !burst_bytes[0]));

   // R7: an interrupt never rises while busy is shown
   p_irq_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intrq) |-> !status[STB_BSY]);
endmodule

bind pkt_pio_engine pkt_pio_checker #(.CNT_W(CNT_W)) i_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_addr    (reg_addr),
   .reg_wr      (reg_wr),
   .reg_rd      (reg_rd),
   .cmd_byte    (reg_wdata[7:0]),
   .intrq       (intrq),
   .status      (status_w),
   .st          (st),
   .burst_bytes (burst_bytes),
   .limit_ok    (limit_ok)
);

// File: tb/test_pkt_pio_engine.sv
`timescale 1ns/1ps
module test_pkt_pio_engine;
   localparam int BLK = 2048;
   localparam int NSB = 2;
   localparam int FAW = $clog2(NSB*BLK);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic intrq;
   logic fill_we = 1'b0;
   logic [FAW-1:0] fill_addr = '0;
   logic [7:0] fill_byte = '0;

   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   pkt_pio_engine #(.BLOCK_BYTES(BLK), .STORE_BLOCKS(NSB)) i_pkt_pio_engine (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .intrq(intrq), .fill_we(fill_we), .fill_addr(fill_addr),
      .fill_byte(fill_byte));

   function automatic logic [7:0] pat(int a);
      return 8'((a * 13) ^ (a >> 7));
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic peek_status(output logic [7:0] s);
      reg_addr = 3'd7;
      #0.5 s = reg_rdata[7:0];
   endtask

   task automatic wait_irq(string tag);
      int guard = 0;
      while (!intrq && guard < 64) begin
         @(negedge clk);
         guard++;
      end
      check(intrq === 1'b1, tag, int'(intrq), 1);
   endtask

   task automatic start_cmd(logic [15:0] limit);
      logic [7:0] s;
      wr(3'd4, {8'h00, limit[7:0]});
      wr(3'd5, {8'h00, limit[15:8]});
      wr(3'd7, 16'h00A0);
      peek_status(s);
      check(s == 8'hC0, "R2 busy after command", s, 8'hC0);
      @(negedge clk);
      peek_status(s);
      check(s == 8'h48 && !intrq, "R2 packet window", {intrq, s}, 8'h48);
   endtask

   task automatic send_packet(logic [7:0] op, logic [31:0] lba, logic [15:0] nb);
      wr(3'd0, {8'h00, op});
      wr(3'd0, {lba[23:16], lba[31:24]});
      wr(3'd0, {lba[7:0], lba[15:8]});
      wr(3'd0, {nb[15:8], 8'h00});
      wr(3'd0, {8'h00, nb[7:0]});
      wr(3'd0, 16'h0000);
   endtask

   task automatic drain(int lba, int nb, int limit, string name);
      int total = nb * BLK;
      int lim_e = limit & ~1;
      int k = 0;
      logic [15:0] d;
      logic [7:0] s;
      while (k < total) begin
         int burst = (total - k < lim_e) ? total - k : lim_e;
         int bad = 0;
         int first_act = 0, first_exp = 0;
         wait_irq({"R5 burst irq ", name});
         rd(3'd7, d);
         check(d[7:0] == 8'h48, {"R5 burst status ", name}, d[7:0], 8'h48);
         check(intrq == 1'b0, {"R8 irq cleared ", name}, int'(intrq), 0);
         for (int i = 0; i < burst / 2; i++) begin
            int b = k + 2 * i;
            int a = (((lba + b / BLK) % NSB) * BLK) + (b % BLK);
            logic [15:0] e = {pat(a + 1), pat(a)};
            rd(3'd0, d);
            if (d != e && bad == 0) begin first_act = d; first_exp = e; end
            if (d != e) bad++;
         end
         check(bad == 0, {"R6 data ", name}, first_act, first_exp);
         k += burst;
         peek_status(s);
         if (k < total)
            check(s == 8'hC0, {"R4 burst length ", name}, s, 8'hC0);
         else
            check(s == 8'h40 && intrq, {"R7 final ", name}, {intrq, s}, 9'h140);
      end
      rd(3'd7, d);
   endtask

   task automatic t_read(int lba, int nb, int limit, string name);
      start_cmd(16'(limit));
      send_packet(8'h28, 32'(lba), 16'(nb));
      drain(lba, nb, limit, name);
   endtask

   task automatic t_reset();
      logic [7:0] s;
      peek_status(s);
      check(s == 8'h40 && !intrq, "R1 reset status", {intrq, s}, 8'h40);
   endtask

   task automatic t_zero_limit(logic [15:0] limit);
      logic [7:0] s;
      logic [15:0] d;
      wr(3'd4, {8'h00, limit[7:0]});
      wr(3'd5, {8'h00, limit[15:8]});
      wr(3'd7, 16'h00A0);
      peek_status(s);
      check(s == 8'h41 && intrq, "R9 zero limit abort", {intrq, s}, 9'h141);
      rd(3'd7, d);
      check(!intrq, "R8 clear after abort", int'(intrq), 0);
   endtask

   task automatic t_bad_opcode();
      logic [7:0] s;
      logic [15:0] d;
      start_cmd(16'd5120);
      send_packet(8'h12, 32'd0, 16'd1);
      peek_status(s);
      check(s == 8'h41 && intrq, "R10 bad opcode", {intrq, s}, 9'h141);
      rd(3'd7, d);
      check(!intrq && d[7:0] == 8'h41, "R8 clear keeps ERR", {intrq, d[7:0]}, 8'h41);
   endtask

   task automatic t_zero_count();
      logic [7:0] s;
      logic [15:0] d;
      start_cmd(16'd5120);
      send_packet(8'h28, 32'd0, 16'd0);
      peek_status(s);
      check(s == 8'h40 && intrq, "R11 zero count", {intrq, s}, 9'h140);
      rd(3'd7, d);
   endtask

   task automatic t_ignored();
      logic [7:0] s;
      logic [15:0] d;
      wr(3'd7, 16'h00EC);
      peek_status(s);
      check(s == 8'h40 && !intrq, "R12 other code ignored", {intrq, s}, 8'h40);
      start_cmd(16'h1402);
      wr(3'd4, 16'h0077);
      wr(3'd7, 16'h00A0);
      rd(3'd4, d);
      check(d[7:0] == 8'h02, "R12 limit locked", d[7:0], 8'h02);
      peek_status(s);
      check(s == 8'h48, "R12 command ignored in packet", s, 8'h48);
      send_packet(8'h28, 32'd1, 16'd1);
      drain(1, 1, 16'h1402, "R12 after ignored");
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int a = 0; a < NSB * BLK; a++) begin
         @(negedge clk);
         fill_we = 1'b1; fill_addr = FAW'(a); fill_byte = pat(a);
      end
      @(negedge clk);
      fill_we = 1'b0;
      t_reset();
      t_read(0, 1, 5120, "R3 single block");
      t_read(1, 5, 5120, "R6 wrap two bursts");
      t_read(0, 3, 4097, "R4 odd limit");
      t_read(1, 1, 512, "R5 four bursts");
      t_zero_limit(16'd0);
      t_zero_limit(16'd1);
      t_bad_opcode();
      t_read(0, 1, 2048, "R10 err cleared");
      t_zero_count();
      t_ignored();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule